// File: doc/BRIEF.md
# Arbitrated Fixed-Latency Line Memory

This block is a word-addressed store that holds lines of four 32-bit words. An instruction-fetch requester and a data requester share it. Either one may read or write a whole line. Every transaction takes a set number of clock cycles, given by a parameter.

A requester keeps its request asserted on every cycle until it is answered. The block answers WAIT on each cycle until the final one, and answers OK on that cycle. On a read, the line is returned in the same OK cycle. On a write, the line is committed at the clock edge that closes the OK cycle. Only one requester owns the store at a time, and the losing requester is not queued.

The word address first wraps modulo the memory size. Its upper bits then select the line that contains it.

Top module: `line_mem_arb`

## Requirements
- R1: A line is four 32-bit words. Word k sits in bits [32k+31:32k] of the write and read buses, and a transaction moves the whole line.
- R2: With `LATENCY` = N > 0, a requester that holds the same request on back-to-back cycles gets WAIT (response 0) for N cycles and OK (response 1) on cycle N+1.
- R3: With `LATENCY` = 0, the first cycle on which a request is presented returns OK.
- R4: The stored line changes only at the clock edge that ends a write's OK cycle. Reads see it from the next cycle on, and it stays unchanged while the write is at WAIT.
- R5: A port's read data is all zeros on every cycle on which that port's response is not OK.
- R6: While one port owns the store, the other port gets WAIT, including on the owner's OK cycle. Those cycles do not count toward the other port's latency.
- R7: After the owner completes, a waiting port becomes the owner on the next cycle and must still wait its own full N cycles.
- R8: Word addresses 4k through 4k+3 all refer to line k.
- R9: The address wraps modulo `MEM_WORDS` as a two's-complement value, so a negative address wraps to the top of memory. With 64 words, 89 maps to 25 and both -10 and -74 map to 54.
- R10: An owner that drops its request before OK abandons the transaction. The other port still gets WAIT on that cycle, ownership is released at the next edge, and the abandoned write leaves memory untouched.
- R11: When both ports request on the same idle cycle, the data port becomes the owner and the fetch port gets WAIT.
- R12: Reset clears every line to zero and leaves the store with no owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Fetch port request, held until OK |
| if_we | input | 1 | Fetch port: 1 = write line, 0 = read line |
| if_addr | input | ADDR_W | Fetch port word address |
| if_wdata | input | WORD_W*LINE_WORDS | Fetch port write line |
| if_rdata | output | WORD_W*LINE_WORDS | Fetch port read line, valid on OK only |
| if_resp | output | 1 | Fetch port response, 1 = OK, 0 = WAIT |
| dp_req | input | 1 | Data port request, held until OK |
| dp_we | input | 1 | Data port: 1 = write line, 0 = read line |
| dp_addr | input | ADDR_W | Data port word address |
| dp_wdata | input | WORD_W*LINE_WORDS | Data port write line |
| dp_rdata | output | WORD_W*LINE_WORDS | Data port read line, valid on OK only |
| dp_resp | output | 1 | Data port response, 1 = OK, 0 = WAIT |

## Verification
The bench builds two copies of the block with a 64-word memory (16 lines), so that wrap-around with addresses past the top and below zero is easy to reach. The first copy uses a latency of 3. This exposes the WAIT count, handover after completion, abandonment partway through a write, and a contender that stalls through the owner's OK cycle. The second copy uses a latency of 0. It covers the single-cycle OK path, including a same-cycle conflict in which the data port wins at once.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } owner_e;

endpackage

// File: rtl/lm_sequencer.sv
module lm_sequencer #(
  parameter int LATENCY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_req,
  input  logic            data_req,
  output logic            serve,
  output logic            sel_data,
  output logic            done,
  output lm_pkg::owner_e  owner
);
  import lm_pkg::*;

  localparam int CW = $clog2(LATENCY + 2);

  owner_e        owner_q, owner_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_eff;

  // Cycles already spent by the owner; a fresh grant starts from zero.
  assign cnt_eff = (owner_q == OWN_NONE) ? '0 : cnt_q;

  always_comb begin
    serve    = 1'b0;
    sel_data = 1'b0;
    unique case (owner_q)
      OWN_NONE: begin
        if (data_req) begin
          serve    = 1'b1;
          sel_data = 1'b1;
        end else if (fetch_req) begin
          serve = 1'b1;
        end
      end
      OWN_FETCH: serve = fetch_req;
      OWN_DATA: begin
        serve    = data_req;
        sel_data = 1'b1;
      end
      default: serve = 1'b0;
    endcase
  end

  assign done = serve && (cnt_eff == CW'(LATENCY));

  always_comb begin
    if (!serve || done) begin
      owner_d = OWN_NONE;
      cnt_d   = '0;
    end else begin
      owner_d = sel_data ? OWN_DATA : OWN_FETCH;
      cnt_d   = cnt_eff + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      cnt_q   <= '0;
    end else begin
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
    end
  end

  assign owner = owner_q;

endmodule

// File: rtl/lm_line_array.sv
module lm_line_array #(
  parameter int LINES  = 64,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);

  logic [LINE_W-1:0] store_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) store_q[i] <= '0;
    end else if (wr_en) begin
      store_q[wr_idx] <= wr_line;
    end
  end

  assign rd_line = store_q[rd_idx];

endmodule

// File: rtl/lm_port_view.sv
module lm_port_view #(
  parameter int LINE_W = 128
) (
  input  logic              done,
  input  logic [LINE_W-1:0] line,
  output logic              resp,
  output logic [LINE_W-1:0] rdata
);

  assign resp  = done;
  assign rdata = done ? line : '0;

endmodule

// File: rtl/line_mem_arb.sv
module line_mem_arb #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int MEM_WORDS  = 256,
  parameter int LATENCY    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         if_req,
  input  logic                         if_we,
  input  logic [ADDR_W-1:0]            if_addr,
  input  logic [WORD_W*LINE_WORDS-1:0] if_wdata,
  output logic [WORD_W*LINE_WORDS-1:0] if_rdata,
  output logic                         if_resp,
  input  logic                         dp_req,
  input  logic                         dp_we,
  input  logic [ADDR_W-1:0]            dp_addr,
  input  logic [WORD_W*LINE_WORDS-1:0] dp_wdata,
  output logic [WORD_W*LINE_WORDS-1:0] dp_rdata,
  output logic                         dp_resp
);

  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int LINES  = MEM_WORDS / LINE_WORDS;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);

  // Wrap modulo the power-of-two depth, then drop the word offset.
  function automatic logic [IDX_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  logic unused_addr_bits;
  assign unused_addr_bits = ^{if_addr[ADDR_W-1:OFF_W+IDX_W], if_addr[OFF_W-1:0],
                              dp_addr[ADDR_W-1:OFF_W+IDX_W], dp_addr[OFF_W-1:0]};

  // Named internal events, observed by the bound checker.
  logic           serve, sel_data, done;
  logic           mem_wr, fetch_done, data_done;
  logic [1:0]     owner_bits;
  lm_pkg::owner_e owner;

  lm_sequencer #(.LATENCY(LATENCY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (if_req),
    .data_req  (dp_req),
    .serve     (serve),
    .sel_data  (sel_data),
    .done      (done),
    .owner     (owner)
  );

  assign owner_bits = owner;

  logic [IDX_W-1:0]  sel_idx;
  logic [LINE_W-1:0] sel_wdata, rd_line;
  logic              sel_we;

  assign sel_idx    = sel_data ? line_of(dp_addr) : line_of(if_addr);
  assign sel_we     = sel_data ? dp_we : if_we;
  assign sel_wdata  = sel_data ? dp_wdata : if_wdata;
  assign mem_wr     = done && sel_we;
  assign fetch_done = done && !sel_data;
  assign data_done  = done && sel_data;

  lm_line_array #(.LINES(LINES), .LINE_W(LINE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mem_wr),
    .wr_idx  (sel_idx),
    .wr_line (sel_wdata),
    .rd_idx  (sel_idx),
    .rd_line (rd_line)
  );

  logic [1:0]        port_done;
  logic [1:0]        port_resp;
  logic [LINE_W-1:0] port_rdata [2];

  assign port_done = {data_done, fetch_done};

  for (genvar p = 0; p < 2; p++) begin : g_port
    lm_port_view #(.LINE_W(LINE_W)) u_view (
      .done  (port_done[p]),
      .line  (rd_line),
      .resp  (port_resp[p]),
      .rdata (port_rdata[p])
    );
  end

  assign if_resp  = port_resp[0];
  assign if_rdata = port_rdata[0];
  assign dp_resp  = port_resp[1];
  assign dp_rdata = port_rdata[1];

endmodule

// File: rtl/line_mem_arb_chk.sv
module line_mem_arb_chk #(
  parameter int LINE_W  = 128,
  parameter int LATENCY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              if_req,
  input logic              dp_req,
  input logic              if_resp,
  input logic              dp_resp,
  input logic [LINE_W-1:0] if_rdata,
  input logic [LINE_W-1:0] dp_rdata,
  input logic              mem_wr,
  input logic [1:0]        owner_bits
);

  a_r6_single_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_resp && dp_resp));

  a_r5_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !if_resp |-> (if_rdata == '0));

  a_r5_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_resp |-> (dp_rdata == '0));

  a_r4_write_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (if_resp || dp_resp));

  a_r2_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((LATENCY > 0) && if_resp) |-> $past(if_req));

  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((LATENCY > 0) && dp_resp) |-> $past(dp_req));

  a_r10_fetch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_bits == 2'd1 && !if_req) |=> (owner_bits == 2'd0));

  a_r10_data_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_bits == 2'd2 && !dp_req) |=> (owner_bits == 2'd0));

  a_r11_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_bits == 2'd0 && if_req && dp_req) |-> !if_resp);

endmodule

bind line_mem_arb line_mem_arb_chk #(.LINE_W(LINE_W), .LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .if_req     (if_req),
  .dp_req     (dp_req),
  .if_resp    (if_resp),
  .dp_resp    (dp_resp),
  .if_rdata   (if_rdata),
  .dp_rdata   (dp_rdata),
  .mem_wr     (mem_wr),
  .owner_bits (owner_bits)
);

// File: tb/line_mem_arb_tb.sv
`timescale 1ns/1ps
module line_mem_arb_tb;

  localparam int LAT   = 3;
  localparam int WORDS = 64;
  localparam int LW    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // Copy with latency 3
  logic          f_req = 0, f_we = 0, d_req = 0, d_we = 0;
  logic [31:0]   f_addr = 0, d_addr = 0;
  logic [LW-1:0] f_wd = 0, d_wd = 0, f_rd, d_rd;
  logic          f_ok, d_ok;

  // Copy with latency 0
  logic          z_freq = 0, z_fwe = 0, z_dreq = 0, z_dwe = 0;
  logic [31:0]   z_faddr = 0, z_daddr = 0;
  logic [LW-1:0] z_fwd = 0, z_dwd = 0, z_frd, z_drd;
  logic          z_fok, z_dok;

  line_mem_arb #(.MEM_WORDS(WORDS), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_req(f_req), .if_we(f_we), .if_addr(f_addr), .if_wdata(f_wd),
    .if_rdata(f_rd), .if_resp(f_ok),
    .dp_req(d_req), .dp_we(d_we), .dp_addr(d_addr), .dp_wdata(d_wd),
    .dp_rdata(d_rd), .dp_resp(d_ok));

  line_mem_arb #(.MEM_WORDS(WORDS), .LATENCY(0)) u_dut0 (
    .clk(clk), .rst_n(rst_n),
    .if_req(z_freq), .if_we(z_fwe), .if_addr(z_faddr), .if_wdata(z_fwd),
    .if_rdata(z_frd), .if_resp(z_fok),
    .dp_req(z_dreq), .dp_we(z_dwe), .dp_addr(z_daddr), .dp_wdata(z_dwd),
    .dp_rdata(z_drd), .dp_resp(z_dok));

  // Behavioural reference for the latency-3 copy
  int            m_owner = 0;   // 0 idle, 1 fetch, 2 data
  int            m_spent = 0;
  logic [LW-1:0] m_mem [WORDS/4];

  function automatic int wrap_line(input int a);
    int w;
    w = ((a % WORDS) + WORDS) % WORDS;
    return w / 4;
  endfunction

  function automatic logic [LW-1:0] mk(input int base);
    logic [LW-1:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = 32'(base + k);
    return l;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag,
                     input logic fr, input logic fw, input int fa, input int fbase,
                     input logic dr, input logic dw, input int da, input int dbase);
    int srv, spent, fi, di;
    logic ok;
    @(negedge clk);
    f_req = fr; f_we = fw; f_addr = 32'(fa); f_wd = mk(fbase);
    d_req = dr; d_we = dw; d_addr = 32'(da); d_wd = mk(dbase);
    #1;
    spent = (m_owner == 0) ? 0 : m_spent;
    if (m_owner == 0) srv = dr ? 2 : (fr ? 1 : 0);
    else if (m_owner == 1) srv = fr ? 1 : 0;
    else srv = dr ? 2 : 0;
    ok = (srv != 0) && (spent == LAT);
    fi = wrap_line(fa);
    di = wrap_line(da);
    check(tag, "fetch resp", LW'(f_ok), LW'(ok && srv == 1));
    check(tag, "data resp",  LW'(d_ok), LW'(ok && srv == 2));
    check(tag, "fetch rdata", f_rd, (ok && srv == 1) ? m_mem[fi] : '0);
    check(tag, "data rdata",  d_rd, (ok && srv == 2) ? m_mem[di] : '0);
    if (ok && srv == 1 && fw) m_mem[fi] = mk(fbase);
    if (ok && srv == 2 && dw) m_mem[di] = mk(dbase);
    if (srv == 0 || ok) begin m_owner = 0; m_spent = 0; end
    else begin m_owner = srv; m_spent = spent + 1; end
  endtask

  task automatic cyc0(input string tag,
                      input logic fr, input logic fw, input int fa, input int fbase,
                      input logic dr, input logic dw, input int da, input int dbase,
                      input logic e_fok, input logic [LW-1:0] e_frd,
                      input logic e_dok, input logic [LW-1:0] e_drd);
    @(negedge clk);
    z_freq = fr; z_fwe = fw; z_faddr = 32'(fa); z_fwd = mk(fbase);
    z_dreq = dr; z_dwe = dw; z_daddr = 32'(da); z_dwd = mk(dbase);
    #1;
    check(tag, "z fetch resp", LW'(z_fok), LW'(e_fok));
    check(tag, "z fetch rdata", z_frd, e_frd);
    check(tag, "z data resp", LW'(z_dok), LW'(e_dok));
    check(tag, "z data rdata", z_drd, e_drd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS/4; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: idle after reset
    cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0);

    // R2/R1: data write to line 0, held until OK
    for (int c = 0; c < 4; c++) cyc("R2", 0, 0, 0, 0, 1, 1, 0, 32'h11223344);
    // R8/R5/R1: read through address 3 of the same line
    for (int c = 0; c < 4; c++) cyc("R8", 0, 0, 0, 0, 1, 0, 3, 0);

    // R11/R6: both start together, data wins and fetch stalls through its OK
    for (int c = 0; c < 4; c++) cyc("R11", 1, 0, 8, 0, 1, 1, 8, 32'h55660000);
    // R7/R4: fetch now takes its own full latency and sees the new line
    for (int c = 0; c < 4; c++) cyc("R7", 1, 0, 9, 0, 0, 0, 0, 0);

    // R10: fetch write abandoned after two cycles; data blocked on drop cycle
    for (int c = 0; c < 2; c++) cyc("R10", 1, 1, 12, 32'h7700aa00, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 1, 0, 12, 0);
    // R4: line 3 still reads zero after the abandoned write
    for (int c = 0; c < 4; c++) cyc("R4", 0, 0, 0, 0, 1, 0, 12, 0);

    // R9: wrap above the top and below zero
    for (int c = 0; c < 4; c++) cyc("R9", 0, 0, 0, 0, 1, 1, WORDS + 25, 32'h0a0b0000);
    for (int c = 0; c < 4; c++) cyc("R9", 1, 0, 25, 0, 0, 0, 0, 0);
    for (int c = 0; c < 4; c++) cyc("R9", 1, 1, -10, 32'h0c0d0000, 0, 0, 0, 0);
    for (int c = 0; c < 4; c++) cyc("R9", 0, 0, 0, 0, 1, 0, -(WORDS + 10), 0);

    // R12: untouched line reads zero
    for (int c = 0; c < 4; c++) cyc("R12", 1, 0, 40, 0, 0, 0, 0, 0);

    // R3: zero-latency copy
    cyc0("R3", 0, 0, 0, 0, 1, 1, 5, 32'h33000000, 0, '0, 1, '0);
    cyc0("R11", 1, 0, 4, 0, 1, 0, 7, 0, 0, '0, 1, mk(32'h33000000));
    cyc0("R3", 1, 0, 4, 0, 0, 0, 0, 0, 1, mk(32'h33000000), 0, '0);

    cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule